// File: doc/BRIEF.md
# Sentry Jump Unit

This unit resolves the target of a register-indirect jump-and-link in a small in-order core whose pointers are capabilities. It checks that the target is a valid, executable capability. When the target is sealed as an entry point (a sentry), it works out what the jump does to the interrupt-enable state. It returns the unsealed program-counter capability, the new interrupt-enable value, a link capability for the destination register, and a fault flag. A sentry can only be jumped to. Its object type selects one of three effects on interrupts: keep them as they are, turn them off, or turn them on. Two further object types are return sentries, which put back a disabled or an enabled state.

The link is itself a return sentry. Its object type records whether interrupts were enabled before the jump, so a later jump through the link restores the caller's state in a structured way. The pipeline, the CSR file and the trap logic are outside the unit. A faulting jump is only reported, and the interrupt-enable state passes through unchanged. One request is accepted per cycle, and its response appears one clock later.

Top module: `sentry_jump_unit`

## Requirements
- R1: After reset, rsp_o, fault_o, link_we_o and ie_o are all 0.
- R2: A request with req_i high gives rsp_o high on the following cycle. When req_i is low, rsp_o, fault_o and link_we_o are 0 on the following cycle.
- R3: The jump faults if the target tag is 0, or if the execute permission bit (bit 1 of tgt_perm_i) is 0.
- R4: A tagged, executable target whose object type is 6 or 7 (sealed, but not a sentry type) faults.
- R5: On a fault, ie_o equals ie_i, pc_tag_o is 0 and link_we_o is 0.
- R6: An unsealed target (object type 0) leaves ie_o equal to ie_i.
- R7: Sentry object type 1 keeps the interrupt state, type 2 forces ie_o to 0, and type 3 forces ie_o to 1.
- R8: Return sentry object type 4 forces ie_o to 0, and type 5 forces ie_o to 1.
- R9: On a legal jump, pc_tag_o is 1, pc_otype_o is 0, and pc_addr_o and pc_perm_o equal the target's address and permissions.
- R10: The link capability has tag 1, address next_pc_i and permissions pcc_perm_i. Its object type is 5 when ie_i was 1 before the jump, and 4 otherwise.
- R11: link_rd_o repeats rd_i. When rd_i is 0, link_we_o is 0, but the sentry's interrupt effect still applies. Otherwise link_we_o is 1 on every legal jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_i | input | 1 | jump request |
| tgt_tag_i | input | 1 | target validity tag |
| tgt_perm_i | input | PERM_W | target permissions |
| tgt_otype_i | input | OTYPE_W | target object type |
| tgt_addr_i | input | ADDR_W | target address |
| ie_i | input | 1 | interrupt enable before the jump |
| next_pc_i | input | ADDR_W | address of the instruction after the jump |
| pcc_perm_i | input | PERM_W | permissions of the current program-counter capability |
| rd_i | input | REG_W | destination register index |
| rsp_o | output | 1 | response valid |
| fault_o | output | 1 | jump fault |
| pc_tag_o | output | 1 | new program-counter tag |
| pc_perm_o | output | PERM_W | new program-counter permissions |
| pc_otype_o | output | OTYPE_W | new program-counter object type |
| pc_addr_o | output | ADDR_W | new program-counter address |
| ie_o | output | 1 | interrupt enable after the jump |
| link_we_o | output | 1 | link write enable |
| link_rd_o | output | REG_W | link destination register |
| link_tag_o | output | 1 | link tag |
| link_perm_o | output | PERM_W | link permissions |
| link_otype_o | output | OTYPE_W | link object type (return sentry) |
| link_addr_o | output | ADDR_W | link address |

## Verification
Two effects can happen on one response: a change of interrupt state and the capture of the link. The link must record the state from before the change, while ie_o already shows the state after it. The sweep covers every object type with both values of ie_i, so a disabling sentry entered with interrupts on, and an enabling one entered with them off, each occur with a nonzero destination register. Every response is judged on both fronts: ie_o against the effect of the type, and link_otype_o against the incoming ie_i. Any mix-up between the pre-jump and post-jump values therefore shows on one of the two outputs.

// File: rtl/sj_pkg.sv
package sj_pkg;

   typedef enum logic [2:0] {
      SJ_PLAIN   = 3'd0,
      SJ_KEEP    = 3'd1,
      SJ_DIS     = 3'd2,
      SJ_EN      = 3'd3,
      SJ_RET_DIS = 3'd4,
      SJ_RET_EN  = 3'd5,
      SJ_BAD     = 3'd6
   } sj_kind_e;

endpackage

// File: rtl/sj_target_check.sv
module sj_target_check
   import sj_pkg::*;
#(
   parameter int PERM_W     = 6,
   parameter int OTYPE_W    = 3,
   parameter int EXEC_BIT   = 1,
   parameter int OT_KEEP    = 1,
   parameter int OT_DIS     = 2,
   parameter int OT_EN      = 3,
   parameter int OT_RET_DIS = 4,
   parameter int OT_RET_EN  = 5
) (
   input  logic               tag_i,
   input  logic [PERM_W-1:0]  perm_i,
   input  logic [OTYPE_W-1:0] otype_i,
   output sj_kind_e           kind_o,
   output logic               fault_o
);

   localparam logic [OTYPE_W-1:0] L_KEEP = OTYPE_W'(OT_KEEP);
   localparam logic [OTYPE_W-1:0] L_DIS  = OTYPE_W'(OT_DIS);
   localparam logic [OTYPE_W-1:0] L_EN   = OTYPE_W'(OT_EN);
   localparam logic [OTYPE_W-1:0] L_RDIS = OTYPE_W'(OT_RET_DIS);
   localparam logic [OTYPE_W-1:0] L_REN  = OTYPE_W'(OT_RET_EN);

   logic usable;
   assign usable = tag_i & perm_i[EXEC_BIT];

   always_comb begin
      if (otype_i == '0)          kind_o = SJ_PLAIN;
      else if (otype_i == L_KEEP) kind_o = SJ_KEEP;
      else if (otype_i == L_DIS)  kind_o = SJ_DIS;
      else if (otype_i == L_EN)   kind_o = SJ_EN;
      else if (otype_i == L_RDIS) kind_o = SJ_RET_DIS;
      else if (otype_i == L_REN)  kind_o = SJ_RET_EN;
      else                        kind_o = SJ_BAD;
   end

   assign fault_o = ~usable | (kind_o == SJ_BAD);

endmodule

// File: rtl/sj_ie_select.sv
module sj_ie_select
   import sj_pkg::*;
(
   input  sj_kind_e kind_i,
   input  logic     fault_i,
   input  logic     ie_i,
   output logic     ie_o
);

   always_comb begin
      ie_o = ie_i;
      if (!fault_i) begin
         unique case (kind_i)
            SJ_DIS, SJ_RET_DIS: ie_o = 1'b0;
            SJ_EN,  SJ_RET_EN:  ie_o = 1'b1;
            default:            ie_o = ie_i;
         endcase
      end
   end

endmodule

// File: rtl/sj_link_gen.sv
module sj_link_gen #(
   parameter int ADDR_W     = 32,
   parameter int PERM_W     = 6,
   parameter int OTYPE_W    = 3,
   parameter int REG_W      = 5,
   parameter int OT_RET_DIS = 4,
   parameter int OT_RET_EN  = 5
) (
   input  logic               fault_i,
   input  logic               ie_i,
   input  logic [ADDR_W-1:0]  next_pc_i,
   input  logic [PERM_W-1:0]  pcc_perm_i,
   input  logic [REG_W-1:0]   rd_i,
   output logic               we_o,
   output logic               tag_o,
   output logic [PERM_W-1:0]  perm_o,
   output logic [OTYPE_W-1:0] otype_o,
   output logic [ADDR_W-1:0]  addr_o
);

   assign we_o    = ~fault_i & (rd_i != '0);
   assign tag_o   = 1'b1;
   assign perm_o  = pcc_perm_i;
   assign otype_o = ie_i ? OTYPE_W'(OT_RET_EN) : OTYPE_W'(OT_RET_DIS);
   assign addr_o  = next_pc_i;

endmodule

// File: rtl/sentry_jump_unit.sv
module sentry_jump_unit
   import sj_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PERM_W     = 6,
   parameter int OTYPE_W    = 3,
   parameter int REG_W      = 5,
   parameter int EXEC_BIT   = 1,
   parameter int OT_KEEP    = 1,
   parameter int OT_DIS     = 2,
   parameter int OT_EN      = 3,
   parameter int OT_RET_DIS = 4,
   parameter int OT_RET_EN  = 5,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_i,
   input  logic               tgt_tag_i,
   input  logic [PERM_W-1:0]  tgt_perm_i,
   input  logic [OTYPE_W-1:0] tgt_otype_i,
   input  logic [ADDR_W-1:0]  tgt_addr_i,
   input  logic               ie_i,
   input  logic [ADDR_W-1:0]  next_pc_i,
   input  logic [PERM_W-1:0]  pcc_perm_i,
   input  logic [REG_W-1:0]   rd_i,
   output logic               rsp_o,
   output logic               fault_o,
   output logic               pc_tag_o,
   output logic [PERM_W-1:0]  pc_perm_o,
   output logic [OTYPE_W-1:0] pc_otype_o,
   output logic [ADDR_W-1:0]  pc_addr_o,
   output logic               ie_o,
   output logic               link_we_o,
   output logic [REG_W-1:0]   link_rd_o,
   output logic               link_tag_o,
   output logic [PERM_W-1:0]  link_perm_o,
   output logic [OTYPE_W-1:0] link_otype_o,
   output logic [ADDR_W-1:0]  link_addr_o
);

   localparam int MAX_OT = (1 << OTYPE_W) - 1;

   // elaboration-time parameter checks
   if (OTYPE_W < 3) begin : g_bad_otw
      $error("OTYPE_W must be at least 3");
   end
   if (EXEC_BIT >= PERM_W) begin : g_bad_exec
      $error("EXEC_BIT outside permission field");
   end
   if (OT_RET_EN > MAX_OT || OT_KEEP == 0 || OT_DIS == 0 || OT_EN == 0 ||
       OT_RET_DIS == 0 || OT_RET_EN == 0) begin : g_bad_ot
      $error("sentry object types must be nonzero and fit OTYPE_W");
   end

   sj_kind_e kind;
   logic     c_fault, c_ie, c_link_we, c_link_tag;
   logic [PERM_W-1:0]  c_link_perm;
   logic [OTYPE_W-1:0] c_link_otype;
   logic [ADDR_W-1:0]  c_link_addr;

   sj_target_check #(
      .PERM_W(PERM_W), .OTYPE_W(OTYPE_W), .EXEC_BIT(EXEC_BIT),
      .OT_KEEP(OT_KEEP), .OT_DIS(OT_DIS), .OT_EN(OT_EN),
      .OT_RET_DIS(OT_RET_DIS), .OT_RET_EN(OT_RET_EN)
   ) u_check (
      .tag_i(tgt_tag_i), .perm_i(tgt_perm_i), .otype_i(tgt_otype_i),
      .kind_o(kind), .fault_o(c_fault)
   );

   sj_ie_select u_ie (
      .kind_i(kind), .fault_i(c_fault), .ie_i(ie_i), .ie_o(c_ie)
   );

   sj_link_gen #(
      .ADDR_W(ADDR_W), .PERM_W(PERM_W), .OTYPE_W(OTYPE_W), .REG_W(REG_W),
      .OT_RET_DIS(OT_RET_DIS), .OT_RET_EN(OT_RET_EN)
   ) u_link (
      .fault_i(c_fault), .ie_i(ie_i), .next_pc_i(next_pc_i),
      .pcc_perm_i(pcc_perm_i), .rd_i(rd_i), .we_o(c_link_we),
      .tag_o(c_link_tag), .perm_o(c_link_perm), .otype_o(c_link_otype),
      .addr_o(c_link_addr)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rsp_o        <= 1'b0;
            fault_o      <= 1'b0;
            link_we_o    <= 1'b0;
            ie_o         <= 1'b0;
            pc_tag_o     <= 1'b0;
            pc_perm_o    <= '0;
            pc_otype_o   <= '0;
            pc_addr_o    <= '0;
            link_rd_o    <= '0;
            link_tag_o   <= 1'b0;
            link_perm_o  <= '0;
            link_otype_o <= '0;
            link_addr_o  <= '0;
         end else begin
            rsp_o     <= req_i;
            fault_o   <= req_i & c_fault;
            link_we_o <= req_i & c_link_we;
            if (req_i) begin
               ie_o         <= c_ie;
               pc_tag_o     <= ~c_fault;
               pc_perm_o    <= tgt_perm_i;
               pc_otype_o   <= c_fault ? tgt_otype_i : '0;
               pc_addr_o    <= tgt_addr_i;
               link_rd_o    <= rd_i;
               link_tag_o   <= c_link_tag;
               link_perm_o  <= c_link_perm;
               link_otype_o <= c_link_otype;
               link_addr_o  <= c_link_addr;
            end
         end
      end

      // R5: a faulting jump leaves the interrupt state as it was
      a_r5_fault_keeps_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rsp_o && fault_o) |-> (ie_o == $past(ie_i)));
      // R5: no link write and no valid program counter on a fault
      a_r5_fault_no_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
         fault_o |-> (!link_we_o && !pc_tag_o));
      // R9: a legal jump yields an unsealed, tagged program counter
      a_r9_pc_unsealed: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rsp_o && !fault_o) |-> (pc_tag_o && pc_otype_o == '0));
      // R10: link object type follows the pre-jump interrupt state
      a_r10_link_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
         link_we_o |-> (link_otype_o ==
            ($past(ie_i) ? OTYPE_W'(OT_RET_EN) : OTYPE_W'(OT_RET_DIS))));
      // R11: the zero register is never written
      a_r11_no_zero_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (link_rd_o == '0) |-> !link_we_o);
      // R2: no response without a request one cycle before
      a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rsp_o |-> $past(req_i));
   end else begin : g_comb
      assign rsp_o        = req_i;
      assign fault_o      = req_i & c_fault;
      assign link_we_o    = req_i & c_link_we;
      assign ie_o         = c_ie;
      assign pc_tag_o     = ~c_fault;
      assign pc_perm_o    = tgt_perm_i;
      assign pc_otype_o   = c_fault ? tgt_otype_i : '0;
      assign pc_addr_o    = tgt_addr_i;
      assign link_rd_o    = rd_i;
      assign link_tag_o   = c_link_tag;
      assign link_perm_o  = c_link_perm;
      assign link_otype_o = c_link_otype;
      assign link_addr_o  = c_link_addr;
   end

endmodule

// File: tb/sentry_jump_unit_tb.sv
module sentry_jump_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        t_tag = 1'b0;
   logic [5:0]  t_perm = '0;
   logic [2:0]  t_ot = '0;
   logic [31:0] t_addr = '0;
   logic        ie = 1'b0;
   logic [31:0] npc = '0;
   logic [5:0]  pcc = '0;
   logic [4:0]  rd = '0;

   logic        rsp, fault, pc_tag, o_ie, lwe, l_tag;
   logic [5:0]  pc_perm, l_perm;
   logic [2:0]  pc_ot, l_ot;
   logic [31:0] pc_addr, l_addr;
   logic [4:0]  l_rd;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sentry_jump_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req),
      .tgt_tag_i(t_tag), .tgt_perm_i(t_perm), .tgt_otype_i(t_ot),
      .tgt_addr_i(t_addr), .ie_i(ie), .next_pc_i(npc), .pcc_perm_i(pcc),
      .rd_i(rd), .rsp_o(rsp), .fault_o(fault), .pc_tag_o(pc_tag),
      .pc_perm_o(pc_perm), .pc_otype_o(pc_ot), .pc_addr_o(pc_addr),
      .ie_o(o_ie), .link_we_o(lwe), .link_rd_o(l_rd), .link_tag_o(l_tag),
      .link_perm_o(l_perm), .link_otype_o(l_ot), .link_addr_o(l_addr)
   );

   task automatic chk(input string req_tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : stim
      logic        e_fault, e_ie, e_we;
      logic        p_ie;
      logic [4:0]  p_rd;
      logic [5:0]  p_perm, p_pcc;
      logic [2:0]  p_ot;
      logic [31:0] p_addr, p_npc;
      bit          pend;

      repeat (3) @(negedge clk);
      chk("R1 rsp", 32'(rsp), 0);
      chk("R1 fault", 32'(fault), 0);
      chk("R1 link_we", 32'(lwe), 0);
      chk("R1 ie", 32'(o_ie), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 idle rsp", 32'(rsp), 0);

      pend = 0;
      e_fault = 0; e_ie = 0; e_we = 0; p_ie = 0; p_rd = '0;
      p_perm = '0; p_pcc = '0; p_ot = '0; p_addr = '0; p_npc = '0;
      for (int i = 0; i < 129; i++) begin
         if (pend) begin
            chk("R2 rsp", 32'(rsp), 1);
            chk("R3 R4 fault", 32'(fault), 32'(e_fault));
            chk("R5 R6 R7 R8 ie", 32'(o_ie), 32'(e_ie));
            chk("R11 link_we", 32'(lwe), 32'(e_we));
            chk("R11 link_rd", 32'(l_rd), 32'(p_rd));
            chk("R9 pc_tag", 32'(pc_tag), 32'(!e_fault));
            chk("R9 pc_addr", pc_addr, p_addr);
            chk("R9 pc_perm", 32'(pc_perm), 32'(p_perm));
            if (!e_fault) chk("R9 pc_otype", 32'(pc_ot), 0);
            chk("R10 link_tag", 32'(l_tag), 1);
            chk("R10 link_otype", 32'(l_ot), p_ie ? 5 : 4);
            chk("R10 link_addr", l_addr, p_npc);
            chk("R10 link_perm", 32'(l_perm), 32'(p_pcc));
         end
         if (i == 128) break;
         // sweep: bit0 tag, bit1 exec, bits2-4 otype, bit5 ie, bit6 rd zero
         t_tag  = i[0];
         t_perm = i[1] ? 6'b101010 : 6'b010101;
         t_ot   = i[4:2];
         ie     = i[5];
         rd     = i[6] ? 5'd0 : 5'(1 + (i % 31));
         t_addr = 32'h1000_0000 + 32'(i) * 32'h44;
         npc    = 32'h2000_0004 + 32'(i) * 4;
         pcc    = 6'(i * 7);
         req    = 1'b1;
         e_fault = !t_tag || !t_perm[1] || (t_ot > 3'd5);
         if (e_fault)                        e_ie = ie;
         else if (t_ot == 3'd2 || t_ot == 3'd4) e_ie = 1'b0;
         else if (t_ot == 3'd3 || t_ot == 3'd5) e_ie = 1'b1;
         else                                   e_ie = ie;
         e_we   = !e_fault && (rd != 0);
         p_ie = ie; p_rd = rd; p_perm = t_perm; p_pcc = pcc; p_ot = t_ot;
         p_addr = t_addr; p_npc = npc;
         pend = 1;
         @(negedge clk);
      end
      if (p_ot != 3'd7) chk("R4 sweep end", 32'(p_ot), 7);

      req = 1'b0;
      @(negedge clk);
      chk("R2 no req rsp", 32'(rsp), 0);
      chk("R2 no req fault", 32'(fault), 0);
      chk("R2 no req link_we", 32'(lwe), 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule